// File: doc/BRIEF.md
# Serial Register Access Slave

A four-wire serial slave that lets an external controller read and write a bank of byte-wide registers. The controller lowers chip select and clocks in frames most significant bit first. The first byte is a header: two mode bits followed by a six-bit register address. Every further byte is data. The bus runs with clock phase 1 and idle-low clock. The slave captures the data input on the falling clock edge and moves its data output on the rising edge.

The serial clock, chip select and data input are passed through a synchroniser into a much faster system clock, and edges are detected there. All register traffic leaves the block on a simple single-cycle port in the system clock domain. The port has an address, write data, a write strobe, a read strobe and a read-data input that is sampled in the cycle of the read strobe. Both write and read bursts step the address by one per byte and wrap at the top of the map.

Two addresses act as command triggers. Writing the magic value 0x96 to one of them fires a one-cycle strobe instead of a register write. Address 0x3C fires a restore-defaults strobe. Address 0x3D fires a clock-calibration strobe.

Top module: `spi_regslave`

## Requirements
- R1: A frame starts with a header byte: bits 7..6 are the mode, bits 5..0 the register address. Mode 00 is a write. The next byte is captured MSB first on falling clock edges and produces exactly one `reg_we` cycle carrying that address and byte.
- R2: In a write, each further byte sent while chip select stays low goes to the next address. The address wraps from 0x3F to 0x00.
- R3: Mode 01 is a read. The block raises `reg_rd` for the header address and shifts that byte out on `miso`, MSB first. Each bit changes after a rising clock edge, so it is stable at the following falling edge.
- R4: In a read, while chip select stays low and the clock keeps running, each further byte comes from the next address. The address wraps from 0x3F to 0x00.
- R5: Writing 0x96 to address 0x3C raises `preset_stb` for exactly one cycle. Writing 0x96 to address 0x3D raises `calib_stb` for exactly one cycle. Neither produces a `reg_we`.
- R6: Any other value written to 0x3C or 0x3D, and the value 0x96 written to any other address, is an ordinary register write.
- R7: Mode codes 10 and 11 are ignored until chip select rises. They cause no write, no read and no strobe.
- R8: `miso_oe` is low whenever chip select is high and high whenever it is low.
- R9: Raising chip select in the middle of a frame discards the partial frame. The next selection is parsed from its first header bit.
- R10: After reset, all strobes and `miso_oe` (with chip select high) are low.
- R11: Two `reg_we` strobes, or two `reg_rd` strobes, never fall in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from controller |
| miso | output | 1 | Serial data to controller |
| miso_oe | output | 1 | Output enable for `miso`; low means the line is released |
| reg_addr | output | AW | Register address for the access port |
| reg_wdata | output | DW | Write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | DW | Read data, sampled in the `reg_rd` cycle |
| preset_stb | output | 1 | Restore-defaults command strobe |
| calib_stb | output | 1 | Clock-calibration command strobe |

## Verification
The bench builds the block with its defaults: a six-bit address, byte data, two synchroniser stages, and 0x3C/0x3D as the command addresses. With only 64 entries, bursts that start at 0x3E or 0x3F cross the wrap point within a few bytes. The command addresses also fall inside the normal map, so the same address can be shown both firing a strobe and storing a plain value. The serial clock half-period is ten system cycles. This leaves room for the synchroniser and for the read prefetch between a falling edge and the next rising edge.

// File: rtl/spi_regslave.sv
module spi_regslave #(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DW-1:0] MAGIC = 'h96,
  parameter logic [AW-1:0] PRESET_ADDR = 'h3C,
  parameter logic [AW-1:0] CALIB_ADDR = 'h3D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata,
  output logic          preset_stb,
  output logic          calib_stb
);
  localparam int MW = 2;
  localparam int HW = MW + AW;
  localparam int LW = (HW > DW) ? HW : DW;
  localparam int CW = $clog2(LW);

  typedef enum logic [1:0] {PH_HDR, PH_DATA, PH_SKIP} phase_t;

  logic [SYNC_STAGES-1:0] sck_p, cs_p, mosi_p;
  logic sck_s, cs_s, mosi_s, sck_q;
  logic fall, rise;
  logic [LW-1:0] sh, nxt;
  logic [CW-1:0] cnt;
  logic [AW-1:0] ptr;
  logic [DW-1:0] tx;
  logic is_rd, miso_q;
  phase_t ph;

  assign sck_s  = sck_p[SYNC_STAGES-1];
  assign cs_s   = cs_p[SYNC_STAGES-1];
  assign mosi_s = mosi_p[SYNC_STAGES-1];
  assign fall   = sck_q & ~sck_s;
  assign rise   = ~sck_q & sck_s;
  assign nxt    = {sh[LW-2:0], mosi_s};

  wire [MW-1:0] hdr_mode = nxt[HW-1 -: MW];
  wire [AW-1:0] hdr_addr = nxt[AW-1:0];
  wire [DW-1:0] rx_byte  = nxt[DW-1:0];
  wire          is_magic = (rx_byte == MAGIC);

  assign miso    = miso_q;
  assign miso_oe = ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p      <= '0;
      cs_p       <= '1;
      mosi_p     <= '0;
      sck_q      <= 1'b0;
      sh         <= '0;
      cnt        <= '0;
      ptr        <= '0;
      tx         <= '0;
      is_rd      <= 1'b0;
      miso_q     <= 1'b0;
      ph         <= PH_HDR;
      reg_addr   <= '0;
      reg_wdata  <= '0;
      reg_we     <= 1'b0;
      reg_rd     <= 1'b0;
      preset_stb <= 1'b0;
      calib_stb  <= 1'b0;
    end else begin
      sck_p  <= {sck_p[SYNC_STAGES-2:0], sck};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_n};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
      sck_q  <= sck_s;
      reg_we     <= 1'b0;
      reg_rd     <= 1'b0;
      preset_stb <= 1'b0;
      calib_stb  <= 1'b0;
      if (reg_rd) tx <= reg_rdata;
      if (cs_s) begin
        ph     <= PH_HDR;
        cnt    <= '0;
        is_rd  <= 1'b0;
        miso_q <= 1'b0;
      end else begin
        if (fall && ph != PH_SKIP) begin
          sh <= nxt;
          if (ph == PH_HDR && cnt == CW'(HW-1)) begin
            cnt <= '0;
            case (hdr_mode)
              2'b00: begin
                ph    <= PH_DATA;
                is_rd <= 1'b0;
                ptr   <= hdr_addr;
              end
              2'b01: begin
                ph       <= PH_DATA;
                is_rd    <= 1'b1;
                reg_rd   <= 1'b1;
                reg_addr <= hdr_addr;
                ptr      <= hdr_addr + 1'b1;
              end
              default: ph <= PH_SKIP;
            endcase
          end else if (ph == PH_DATA && cnt == CW'(DW-1)) begin
            cnt <= '0;
            ptr <= ptr + 1'b1;
            if (is_rd) begin
              reg_rd   <= 1'b1;
              reg_addr <= ptr;
            end else if (is_magic && ptr == PRESET_ADDR) begin
              preset_stb <= 1'b1;
            end else if (is_magic && ptr == CALIB_ADDR) begin
              calib_stb <= 1'b1;
            end else begin
              reg_we    <= 1'b1;
              reg_addr  <= ptr;
              reg_wdata <= rx_byte;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        if (rise && ph == PH_DATA && is_rd) begin
          miso_q <= tx[DW-1];
          tx     <= {tx[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

module spi_regslave_chk (
  input logic clk,
  input logic rst_n,
  input logic reg_we,
  input logic reg_rd,
  input logic preset_stb,
  input logic calib_stb
);
  p_port_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_rd));
  p_we_spaced_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  p_rd_spaced_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  p_preset_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    preset_stb |=> !preset_stb);
  p_calib_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    calib_stb |=> !calib_stb);
  p_cmd_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_stb || calib_stb) |-> (!reg_we && !(preset_stb && calib_stb)));
endmodule

bind spi_regslave spi_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rd(reg_rd),
  .preset_stb(preset_stb), .calib_stb(calib_stb)
);

// File: tb/sim_spi_regslave.sv
module sim_spi_regslave;
  localparam int H = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, reg_we, reg_rd, preset_stb, calib_stb;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [0:63];
  logic [5:0] wa [0:63];
  logic [7:0] wd [0:63];
  int wn = 0, rn = 0, pc = 0, cc = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_regslave u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .preset_stb(preset_stb), .calib_stb(calib_stb)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      if (reg_we) begin
        mem[reg_addr] <= reg_wdata;
        wa[wn[5:0]] <= reg_addr;
        wd[wn[5:0]] <= reg_wdata;
        wn <= wn + 1;
      end
      if (reg_rd) rn <= rn + 1;
      if (preset_stb) pc <= pc + 1;
      if (calib_stb) cc <= cc + 1;
    end
  end

  function automatic logic [7:0] init_val(int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk);
      sck = 1'b1;
      mosi = b[i];
      wait_clk(H);
      r[i] = miso;
      sck = 1'b0;
      wait_clk(H);
    end
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
    spi_bits(b, 8, r);
  endtask

  task automatic sel;
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(H);
  endtask

  task automatic desel;
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(3 * H);
  endtask

  task automatic t_reset;
    check("R10 reg_we", reg_we, 0);
    check("R10 reg_rd", reg_rd, 0);
    check("R10 preset_stb", preset_stb, 0);
    check("R10 calib_stb", calib_stb, 0);
    check("R10 miso_oe", miso_oe, 0);
  endtask

  task automatic t_oe;
    sel();
    check("R8 oe low-cs", miso_oe, 1);
    desel();
    check("R8 oe high-cs", miso_oe, 0);
  endtask

  task automatic t_read_single;
    logic [7:0] r;
    int r0 = rn;
    sel();
    spi_byte({2'b01, 6'h05}, r);
    spi_byte(8'h00, r);
    desel();
    check("R3 read data", r, init_val(5));
    check("R3 read strobes", rn - r0, 2);
  endtask

  task automatic t_read_burst;
    logic [7:0] r0, r1, r2, d;
    int w0 = wn;
    sel();
    spi_byte({2'b01, 6'h3F}, d);
    spi_byte(8'hFF, r0);
    spi_byte(8'hFF, r1);
    spi_byte(8'hFF, r2);
    desel();
    check("R4 burst 0x3F", r0, init_val(63));
    check("R4 burst wrap 0x00", r1, init_val(0));
    check("R4 burst 0x01", r2, init_val(1));
    check("R4 no writes", wn - w0, 0);
  endtask

  task automatic t_write_single;
    logic [7:0] d;
    int w0 = wn;
    sel();
    spi_byte({2'b00, 6'h05}, d);
    spi_byte(8'hA7, d);
    desel();
    check("R1 write count", wn - w0, 1);
    check("R1 write addr", wa[w0[5:0]], 6'h05);
    check("R1 write data", wd[w0[5:0]], 8'hA7);
  endtask

  task automatic t_write_burst;
    logic [7:0] d;
    int w0 = wn;
    sel();
    spi_byte({2'b00, 6'h3E}, d);
    spi_byte(8'h11, d);
    spi_byte(8'h22, d);
    spi_byte(8'h33, d);
    desel();
    check("R2 burst count", wn - w0, 3);
    check("R2 addr 0x3E", wa[w0[5:0]], 6'h3E);
    check("R2 addr 0x3F", wa[6'(w0 + 1)], 6'h3F);
    check("R2 wrap addr 0x00", wa[6'(w0 + 2)], 6'h00);
    check("R2 wrap data", wd[6'(w0 + 2)], 8'h33);
  endtask

  task automatic t_magic;
    logic [7:0] d;
    int w0 = wn, p0 = pc, c0 = cc;
    sel();
    spi_byte({2'b00, 6'h3C}, d);
    spi_byte(8'h96, d);
    desel();
    check("R5 preset one cycle", pc - p0, 1);
    check("R5 no calib", cc - c0, 0);
    sel();
    spi_byte({2'b00, 6'h3D}, d);
    spi_byte(8'h96, d);
    desel();
    check("R5 calib one cycle", cc - c0, 1);
    check("R5 no preset", pc - p0, 1);
    check("R5 no writes", wn - w0, 0);
  endtask

  task automatic t_nonmagic;
    logic [7:0] d;
    int w0 = wn, p0 = pc;
    sel();
    spi_byte({2'b00, 6'h3C}, d);
    spi_byte(8'h55, d);
    desel();
    sel();
    spi_byte({2'b00, 6'h10}, d);
    spi_byte(8'h96, d);
    desel();
    check("R6 writes", wn - w0, 2);
    check("R6 addr 0x3C", wa[w0[5:0]], 6'h3C);
    check("R6 data 0x55", wd[w0[5:0]], 8'h55);
    check("R6 addr 0x10", wa[6'(w0 + 1)], 6'h10);
    check("R6 no preset", pc - p0, 0);
  endtask

  task automatic t_ignored;
    logic [7:0] d;
    int w0 = wn, r0 = rn, p0 = pc, c0 = cc;
    sel();
    spi_byte({2'b10, 6'h07}, d);
    spi_byte(8'hFF, d);
    spi_byte({2'b01, 6'h07}, d);
    desel();
    sel();
    spi_byte({2'b11, 6'h3C}, d);
    spi_byte(8'h96, d);
    desel();
    check("R7 no writes", wn - w0, 0);
    check("R7 no reads", rn - r0, 0);
    check("R7 no strobes", (pc - p0) + (cc - c0), 0);
    sel();
    spi_byte({2'b01, 6'h07}, d);
    spi_byte(8'h00, d);
    desel();
    check("R7 reg 0x07 unchanged", d, init_val(7));
  endtask

  task automatic t_abort;
    logic [7:0] d;
    int w0 = wn;
    sel();
    spi_byte({2'b00, 6'h0A}, d);
    spi_bits(8'hC3, 3, d);
    desel();
    sel();
    spi_byte({2'b00, 6'h0B}, d);
    spi_byte(8'h5A, d);
    desel();
    check("R9 single write", wn - w0, 1);
    check("R9 addr", wa[w0[5:0]], 6'h0B);
    check("R9 data", wd[w0[5:0]], 8'h5A);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    sel();
    spi_byte({2'b01, 6'h05}, d);
    spi_byte(8'h00, d);
    desel();
    check("R1 readback 0x05", d, 8'hA7);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_oe();
    t_read_single();
    t_read_burst();
    t_write_single();
    t_write_burst();
    t_magic();
    t_nonmagic();
    t_ignored();
    t_abort();
    t_readback();
    finish_run();
  end
endmodule